// File: doc/BRIEF.md
# Conditional Micro-op Integer ALU

This block runs one integer register micro-operation per issue. Each micro-op has an operation code, an operand size, a flag-variant bit and an 8-bit extension field. The second operand is either a register value or a sign-extended 8-bit immediate. The result is merged into the old destination value at the operand size, so bytes above that size are kept.

The plain variant of every operation writes the destination and leaves the flags alone. For the arithmetic and logic operations, the flag variant also writes the flags that the extension field enables as a mask. For move, the flag variant is a guarded move. The extension field then selects a condition that is tested on the incoming flags. A move whose condition fails changes neither the destination nor the flags.

Result and flags are registered one cycle after the issue. A small control machine raises `done` for each cycle that follows an issue. It has two states. `ST_IDLE` takes the transition `issue` to `ST_RESP` when `issue_vld` is high, and stays put otherwise. `ST_RESP` takes `issue` (stay in `ST_RESP`) on a back-to-back issue, and `retire` to `ST_IDLE` when no new issue arrives.

Top module: `cuop_alu`

## Requirements
- R1: After reset, `done` is 0 and both `res_out` and `flags_out` are 0.
- R2: The opcode encodings are: 0 add, 1 or, 2 add-with-carry, 3 subtract-with-borrow, 4 and, 5 subtract, 6 xor, 7 compare, 8 move. A plain variant (`flag_var`=0) writes the result and returns `flags_out` equal to the `flags_in` of that issue.
- R3: The `size` encodings are: 0 for 8 bits, 1 for 16 bits, 2 or 3 for the full 32 bits. Result bits above the operand size are copied from the merge base. The merge base is `src1` for move and `dst_old` for every other operation.
- R4: When `imm_sel`=1, the second operand is `imm` sign-extended to 32 bits instead of `src2`.
- R5: In `flags_out` and `flags_in`, the bit positions are: 0 carry C, 1 parity P, 2 aux A, 3 zero Z, 4 sign S, 5 overflow O, 6 extra-carry EC, 7 extra-zero EZ. Each is evaluated at the operand size as follows:
  - Z is set when the sized result is zero.
  - S is the top bit of the sized result.
  - P is set when the low result byte has an even number of ones.
  - EC copies C, and EZ copies Z.
- R6: The flag variant of a non-move operation always executes. Only the flag bits set in `ext` take new values; the other bits keep their `flags_in` values.
- R7: Subtract, compare and subtract-with-borrow add the inverted second operand with a carry-in. C is the carry out at the operand size, so C=1 means no borrow. Compare computes `dst_old` minus the operand and merges that into the destination.
- R8: Add-with-carry adds the incoming C. Subtract-with-borrow also subtracts the incoming C.
- R9: A is the carry out of bit 3. O is set when two same-sign addends give a result of the other sign.
- R10: For or, and and xor, the generated C, A, O and EC are 0.
- R11: A plain move always executes, and no move ever writes flags. Opcodes 9 to 15 return `dst_old` and `flags_in` unchanged.
- R12: A flag-variant move executes only when the condition selected by `ext[4:0]` passes. Otherwise `res_out` equals `dst_old` and `flags_out` equals `flags_in`.
- R13: The condition selector base `ext[3:0]` is coded as:

  | Base | Test |
  |------|------|
  | 0 | always |
  | 1 | C |
  | 2 | Z |
  | 3 | S |
  | 4 | O |
  | 5 | P |
  | 6 | C or Z |
  | 7 | S xor O |
  | 8 | (S xor O) or Z |
  | 9 | EC |
  | 10 | EZ |
  | 11 | EZ or not Z |
  | 12 | A |
  | 13 to 15 | never |

  Setting `ext[4]` inverts the test.
- R14: `done` is high in exactly the cycle after each cycle with `issue_vld` high, so back-to-back issues give back-to-back strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Micro-op issued this cycle |
| op | input | 4 | Operation code |
| flag_var | input | 1 | Flag variant select |
| imm_sel | input | 1 | Use the immediate as second operand |
| size | input | 2 | Operand size code |
| dst_old | input | 32 | Old destination value |
| src1 | input | 32 | First source register |
| src2 | input | 32 | Second source register |
| imm | input | 8 | Immediate operand |
| ext | input | 8 | Flag mask or condition selector |
| flags_in | input | 8 | Current flags |
| done | output | 1 | Result valid strobe |
| res_out | output | 32 | New destination value |
| flags_out | output | 8 | New flags |

## Verification
Every fault inside this block surfaces at the edge that follows the issue. It appears on the outputs in the very next cycle alongside `done`.

- A wrong carry-in or operand inversion shows up as a wrong result word and a wrong C or A bit.
- A broken merge corrupts the bytes above the operand size.
- A bad mask or a bad condition decode leaks flag bits or lets a blocked move write.
- A control machine stuck in one state shows as a missing or extra `done` pulse in the cycle after an issue.

// File: rtl/cuop_pkg.sv
package cuop_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_OR  = 4'd1,
        OP_ADC = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_SUB = 4'd5,
        OP_XOR = 4'd6,
        OP_CMP = 4'd7,
        OP_MOV = 4'd8
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctl_state_e;

    localparam int FB_C  = 0;
    localparam int FB_P  = 1;
    localparam int FB_A  = 2;
    localparam int FB_Z  = 3;
    localparam int FB_S  = 4;
    localparam int FB_O  = 5;
    localparam int FB_EC = 6;
    localparam int FB_EZ = 7;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/cuop_flaggen.sv
module cuop_flaggen
    import cuop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 8
) (
    input  logic [1:0]        size,
    input  logic              is_arith,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W:0]   sum,
    output logic [FLAG_W-1:0] gen
);
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    logic [DATA_W:0] a_ext;
    logic [DATA_W:0] b_ext;
    logic [DATA_W-1:0] szmask;
    int hi;

    assign a_ext = {1'b0, opa};
    assign b_ext = {1'b0, opb};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                hi     = BYTE_W - 1;
                szmask = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            end
            SZ_HALF: begin
                hi     = HALF_W - 1;
                szmask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            end
            default: begin
                hi     = DATA_W - 1;
                szmask = {DATA_W{1'b1}};
            end
        endcase
    end

    always_comb begin
        gen        = '0;
        gen[FB_Z]  = ((res & szmask) == '0);
        gen[FB_S]  = res[hi];
        gen[FB_P]  = ~^res[BYTE_W-1:0];
        gen[FB_EZ] = gen[FB_Z];
        if (is_arith) begin
            gen[FB_C]  = sum[hi+1] ^ a_ext[hi+1] ^ b_ext[hi+1];
            gen[FB_A]  = res[4] ^ opa[4] ^ opb[4];
            gen[FB_O]  = (opa[hi] == opb[hi]) && (res[hi] != opa[hi]);
            gen[FB_EC] = gen[FB_C];
        end
    end

endmodule

// File: rtl/cuop_condeval.sv
module cuop_condeval
    import cuop_pkg::*;
#(
    parameter int FLAG_W = 8,
    parameter int SEL_W  = 5
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    output logic              pass
);
    localparam int BASE_W = SEL_W - 1;

    logic base;

    always_comb begin
        unique case (sel[BASE_W-1:0])
            4'd0:    base = 1'b1;
            4'd1:    base = flags[FB_C];
            4'd2:    base = flags[FB_Z];
            4'd3:    base = flags[FB_S];
            4'd4:    base = flags[FB_O];
            4'd5:    base = flags[FB_P];
            4'd6:    base = flags[FB_C] | flags[FB_Z];
            4'd7:    base = flags[FB_S] ^ flags[FB_O];
            4'd8:    base = (flags[FB_S] ^ flags[FB_O]) | flags[FB_Z];
            4'd9:    base = flags[FB_EC];
            4'd10:   base = flags[FB_EZ];
            4'd11:   base = flags[FB_EZ] | ~flags[FB_Z];
            4'd12:   base = flags[FB_A];
            default: base = 1'b0;
        endcase
        pass = base ^ sel[SEL_W-1];
    end

    always_comb begin
        if (sel == '0) begin
            a_r13_always_passes: assert (pass);
        end
    end

endmodule

// File: rtl/cuop_alu.sv
module cuop_alu
    import cuop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int FLAG_W = 8,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [3:0]        op,
    input  logic              flag_var,
    input  logic              imm_sel,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic [IMM_W-1:0]  imm,
    input  logic [FLAG_W-1:0] ext,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              done,
    output logic [DATA_W-1:0] res_out,
    output logic [FLAG_W-1:0] flags_out
);
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam logic [3:0] OP_LAST = OP_MOV;

    ctl_state_e state_q, state_d;

    logic [DATA_W-1:0] op2, opa, opb, raw, base, szmask, merged;
    logic [DATA_W-1:0] next_res;
    logic [DATA_W:0]   sum;
    logic [FLAG_W-1:0] gen, next_flags;
    logic              cin, is_arith, known, is_mov, cond_pass, exec_ok, upd_flags;

    // operand selection and adder
    always_comb begin
        op2      = imm_sel ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} : src2;
        is_mov   = (op == OP_MOV);
        known    = (op <= OP_LAST);
        opa      = (op == OP_CMP) ? dst_old : src1;
        opb      = op2;
        cin      = 1'b0;
        is_arith = 1'b0;
        unique case (op)
            OP_ADD: is_arith = 1'b1;
            OP_ADC: begin is_arith = 1'b1; cin = flags_in[FB_C]; end
            OP_SUB, OP_CMP: begin is_arith = 1'b1; opb = ~op2; cin = 1'b1; end
            OP_SBB: begin is_arith = 1'b1; opb = ~op2; cin = ~flags_in[FB_C]; end
            default: ;
        endcase
        sum = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
    end

    always_comb begin
        unique case (op)
            OP_OR:   raw = src1 | op2;
            OP_AND:  raw = src1 & op2;
            OP_XOR:  raw = src1 ^ op2;
            OP_MOV:  raw = op2;
            default: raw = sum[DATA_W-1:0];
        endcase
        base = is_mov ? src1 : dst_old;
        unique case (size)
            SZ_BYTE: szmask = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            SZ_HALF: szmask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            default: szmask = {DATA_W{1'b1}};
        endcase
        merged = (base & ~szmask) | (raw & szmask);
    end

    cuop_flaggen #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_flaggen (
        .size     (size),
        .is_arith (is_arith),
        .res      (raw),
        .opa      (opa),
        .opb      (opb),
        .sum      (sum),
        .gen      (gen)
    );

    cuop_condeval #(.FLAG_W(FLAG_W), .SEL_W(SEL_W)) u_condeval (
        .flags (flags_in),
        .sel   (ext[SEL_W-1:0]),
        .pass  (cond_pass)
    );

    always_comb begin
        exec_ok    = known && !(flag_var && is_mov && !cond_pass);
        upd_flags  = known && flag_var && !is_mov;
        next_res   = exec_ok ? merged : dst_old;
        next_flags = upd_flags ? ((flags_in & ~ext) | (gen & ext)) : flags_in;
    end

    // control state machine
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = issue_vld ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = issue_vld ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out   <= '0;
            flags_out <= '0;
        end else if (issue_vld) begin
            res_out   <= next_res;
            flags_out <= next_flags;
        end
    end

    assign done = (state_q == ST_RESP);

    a_r14_done_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(issue_vld));

    a_r2_plain_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !flag_var) |=> (flags_out == $past(flags_in)));

    a_r6_mask_confines: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && flag_var) |=> (((flags_out ^ $past(flags_in)) & ~$past(ext)) == '0));

    a_r3_upper_bytes_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && size == SZ_BYTE && op < OP_MOV)
        |=> (res_out[DATA_W-1:BYTE_W] == $past(dst_old[DATA_W-1:BYTE_W])));

    a_r12_blocked_move_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && flag_var && op == OP_MOV && !cond_pass)
        |=> (res_out == $past(dst_old) && flags_out == $past(flags_in)));

endmodule

// File: tb/sim_cuop_alu.sv
module sim_cuop_alu;

    typedef struct {
        logic [31:0] r;
        logic [7:0]  f;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [3:0]  op = '0;
    logic        flag_var = 1'b0;
    logic        imm_sel = 1'b0;
    logic [1:0]  size = '0;
    logic [31:0] dst_old = '0, src1 = '0, src2 = '0;
    logic [7:0]  imm = '0, ext = '0, flags_in = '0;
    logic        done;
    logic [31:0] res_out;
    logic [7:0]  flags_out;

    int   checks = 0;
    int   fails = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    cuop_alu u0 (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .op(op),
        .flag_var(flag_var), .imm_sel(imm_sel), .size(size),
        .dst_old(dst_old), .src1(src1), .src2(src2), .imm(imm),
        .ext(ext), .flags_in(flags_in), .done(done),
        .res_out(res_out), .flags_out(flags_out)
    );

    function automatic logic cond_ok(input logic [4:0] s, input logic [7:0] f);
        logic b;
        case (s[3:0])
            4'd0:  b = 1'b1;
            4'd1:  b = f[0];
            4'd2:  b = f[3];
            4'd3:  b = f[4];
            4'd4:  b = f[5];
            4'd5:  b = f[1];
            4'd6:  b = f[0] || f[3];
            4'd7:  b = f[4] != f[5];
            4'd8:  b = (f[4] != f[5]) || f[3];
            4'd9:  b = f[6];
            4'd10: b = f[7];
            4'd11: b = f[7] || !f[3];
            4'd12: b = f[2];
            default: b = 1'b0;
        endcase
        return s[4] ? !b : b;
    endfunction

    task automatic model(input logic [3:0] o, input logic fv, input logic is_imm,
                         input logic [1:0] sz, input logic [31:0] d, s1, s2,
                         input logic [7:0] im, input logic [7:0] ex, input logic [7:0] fi,
                         output logic [31:0] r, output logic [7:0] f);
        logic [63:0] m, xs, bs, t;
        logic [31:0] b, v;
        int   hi;
        logic c, a, ov, arith, cy;
        m  = (sz == 2'd0) ? 64'hFF : (sz == 2'd1) ? 64'hFFFF : 64'hFFFF_FFFF;
        hi = (sz == 2'd0) ? 7 : (sz == 2'd1) ? 15 : 31;
        b  = is_imm ? {{24{im[7]}}, im} : s2;
        xs = ((o == 4'd7) ? {32'h0, d} : {32'h0, s1}) & m;
        bs = {32'h0, b} & m;
        c = 1'b0; a = 1'b0; ov = 1'b0; arith = 1'b0; v = '0;
        cy = fi[0];
        case (o)
            4'd0, 4'd2: begin
                arith = 1'b1;
                t = xs + bs + ((o == 4'd2) ? {63'h0, cy} : 64'h0);
                c = t[hi+1];
                a = ((xs & 15) + (bs & 15) + ((o == 4'd2) ? {63'h0, cy} : 64'h0)) > 15;
                v = t[31:0];
                ov = (xs[hi] == bs[hi]) && (v[hi] != xs[hi]);
            end
            4'd3, 4'd5, 4'd7: begin
                arith = 1'b1;
                t = xs - bs - ((o == 4'd3) ? {63'h0, cy} : 64'h0);
                c = xs >= (bs + ((o == 4'd3) ? {63'h0, cy} : 64'h0));
                a = (xs & 15) >= ((bs & 15) + ((o == 4'd3) ? {63'h0, cy} : 64'h0));
                v = t[31:0];
                ov = (xs[hi] != bs[hi]) && (v[hi] != xs[hi]);
            end
            4'd1: v = s1 | b;
            4'd4: v = s1 & b;
            4'd6: v = s1 ^ b;
            4'd8: v = b;
            default: v = d;
        endcase
        if (o > 4'd8) begin
            r = d; f = fi;
        end else if (o == 4'd8) begin
            f = fi;
            if (fv && !cond_ok(ex[4:0], fi)) r = d;
            else r = (s1 & ~m[31:0]) | (v & m[31:0]);
        end else begin
            logic [7:0] g;
            r = (d & ~m[31:0]) | (v & m[31:0]);
            g = '0;
            g[3] = ((v & m[31:0]) == 0);
            g[4] = v[hi];
            g[1] = ~^v[7:0];
            g[7] = g[3];
            if (arith) begin
                g[0] = c; g[2] = a; g[5] = ov; g[6] = c;
            end
            f = fv ? ((fi & ~ex) | (g & ex)) : fi;
        end
    endtask

    task automatic issue(input string tag, input logic [3:0] o, input logic fv,
                         input logic is_imm, input logic [1:0] sz,
                         input logic [31:0] d, s1, s2, input logic [7:0] im,
                         input logic [7:0] ex, input logic [7:0] fi);
        exp_t e;
        @(negedge clk);
        op = o; flag_var = fv; imm_sel = is_imm; size = sz;
        dst_old = d; src1 = s1; src2 = s2; imm = im; ext = ex; flags_in = fi;
        issue_vld = 1'b1;
        model(o, fv, is_imm, sz, d, s1, s2, im, ex, fi, e.r, e.f);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        issue_vld = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // monitor: pops expected items as done strobes arrive
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk("R14 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " result"}, res_out, e.r);
                chk({e.tag, " flags"}, {24'h0, flags_out}, {24'h0, e.f});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", {31'h0, done}, 32'h0);
        chk("R1 res", res_out, 32'h0);
        chk("R1 flags", {24'h0, flags_out}, 32'h0);

        // R2 plain add, flags passed through
        issue("R2 plain add", 4'd0, 1'b0, 1'b0, 2'd2, 32'h0, 32'h1234_5678, 32'h1111_1111, 8'h0, 8'hFF, 8'hA5);
        // R3 byte merge keeps upper bytes
        issue("R3 byte add merge", 4'd0, 1'b0, 1'b0, 2'd0, 32'hDEAD_BE00, 32'h0000_00F0, 32'h0000_0020, 8'h0, 8'h0, 8'h00);
        issue("R3 half xor merge", 4'd6, 1'b1, 1'b0, 2'd1, 32'hCAFE_0000, 32'h0000_FFFF, 32'h0000_00FF, 8'h0, 8'hFF, 8'h00);
        // R4 immediate sign extension
        issue("R4 imm sign ext", 4'd0, 1'b1, 1'b1, 2'd1, 32'h5555_0000, 32'h0000_0005, 32'hFFFF_FFFF, 8'hFE, 8'hFF, 8'h00);
        // R5 zero, parity, extra flags
        issue("R5 add wrap to zero", 4'd0, 1'b1, 1'b0, 2'd2, 32'h0, 32'hFFFF_FFFF, 32'h1, 8'h0, 8'hFF, 8'h00);
        // R6 partial mask
        issue("R6 mask Z only", 4'd0, 1'b1, 1'b0, 2'd2, 32'h0, 32'hFFFF_FFFF, 32'h1, 8'h0, 8'h08, 8'h31);
        idle();
        // R7 subtract and compare
        issue("R7 sub no borrow", 4'd5, 1'b1, 1'b0, 2'd2, 32'h0, 32'd5, 32'd3, 8'h0, 8'hFF, 8'h00);
        issue("R7 sub borrow", 4'd5, 1'b1, 1'b0, 2'd0, 32'hAB00_0000, 32'd3, 32'd5, 8'h0, 8'hFF, 8'hFF);
        issue("R7 cmp equal", 4'd7, 1'b1, 1'b1, 2'd2, 32'h0000_0010, 32'h9999, 32'h0, 8'h10, 8'hFF, 8'h00);
        // R8 carry-in paths
        issue("R8 adc with C", 4'd2, 1'b1, 1'b0, 2'd0, 32'h0, 32'h0F, 32'h00, 8'h0, 8'hFF, 8'h01);
        issue("R8 sbb with C", 4'd3, 1'b1, 1'b0, 2'd1, 32'h0, 32'h0000_0010, 32'h0000_0010, 8'h0, 8'hFF, 8'h01);
        // R9 overflow and aux
        issue("R9 byte overflow", 4'd0, 1'b1, 1'b0, 2'd0, 32'h0, 32'h7F, 32'h01, 8'h0, 8'hFF, 8'h00);
        // R10 logic ops clear arithmetic flags
        issue("R10 and clears C", 4'd4, 1'b1, 1'b0, 2'd2, 32'h0, 32'h8000_00F0, 32'hF000_000F, 8'h0, 8'hFF, 8'hFF);
        issue("R10 or", 4'd1, 1'b1, 1'b0, 2'd2, 32'h0, 32'h8000_0000, 32'h3, 8'h0, 8'h65, 8'hFF);
        idle();
        // R11 moves and unknown opcode
        issue("R11 plain mov byte", 4'd8, 1'b0, 1'b0, 2'd0, 32'h0, 32'h1122_3344, 32'h0000_00AA, 8'h0, 8'h00, 8'h5A);
        issue("R11 unknown op", 4'd12, 1'b1, 1'b0, 2'd2, 32'h7777_7777, 32'h1, 32'h2, 8'h0, 8'hFF, 8'h3C);
        // R12 guarded move
        issue("R12 mov cond true", 4'd8, 1'b1, 1'b1, 2'd2, 32'h1111_1111, 32'h0, 32'h0, 8'h80, 8'h02, 8'h08);
        issue("R12 mov cond false", 4'd8, 1'b1, 1'b0, 2'd2, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 8'h0, 8'h02, 8'h00);
        // R13 selector variety
        issue("R13 inverted always", 4'd8, 1'b1, 1'b0, 2'd2, 32'hAAAA_0000, 32'h0, 32'h5, 8'h0, 8'h10, 8'h00);
        issue("R13 S xor O", 4'd8, 1'b1, 1'b0, 2'd2, 32'h0, 32'h0, 32'h6, 8'h0, 8'h07, 8'h10);
        issue("R13 not C or Z", 4'd8, 1'b1, 1'b0, 2'd2, 32'h0, 32'h0, 32'h7, 8'h0, 8'h16, 8'h01);
        issue("R13 EZ or not Z", 4'd8, 1'b1, 1'b0, 2'd2, 32'h0, 32'h0, 32'h8, 8'h0, 8'h0B, 8'h08);
        issue("R13 aux", 4'd8, 1'b1, 1'b0, 2'd2, 32'h0, 32'h0, 32'h9, 8'h0, 8'h0C, 8'h04);
        issue("R13 never", 4'd8, 1'b1, 1'b0, 2'd2, 32'h4444_4444, 32'h0, 32'hA, 8'h0, 8'h0E, 8'hFF);
        idle();
        // R14 strobe ends after last issue
        @(negedge clk);
        chk("R14 done low when idle", {31'h0, done}, 32'h0);
        chk("R14 all results retired", q.size(), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule